// File: doc/BRIEF.md
# SPI Register File with Buffer Handshake and Interrupt Flags

This block is the software-facing side of a synchronous serial port. It sits between a byte-wide addressed register bus and a separate shift engine. It holds the frame configuration (clock phase and polarity, bit order, character length, master select, pin mode), a 16-bit clock divisor, a one-deep transmit buffer, a one-deep receive buffer, and the interrupt enables and flags for each direction.

The flags change only as side effects of bus accesses and engine events. A write to the transmit buffer clears the transmit flag. The flag is set again when the shift engine takes the byte, which can happen well before the byte has finished shifting out. Each character delivered by the engine sets the receive flag. A character that arrives while the previous one is still unread also sets the overrun flag. A read of the receive buffer clears both flags. A software reset bit, set out of power-up, forces a defined state: the transmit flag set, and every other flag and both enables cleared.

A listen bit turns on internal loopback. When it is set, the receive serial path is fed from the transmit serial line instead of the external data-in pin.

Top module: `spi_regfile`

Register map (3-bit address): 0 divisor low byte, 1 divisor high byte, 2 frame control, 3 reset control (bit 0 software reset, other bits read 0), 4 status, 5 receive buffer (read only), 6 transmit buffer, 7 interrupt register {4'b0, tx flag bit 3, rx flag bit 2, tx enable bit 1, rx enable bit 0}. In register 7 only the enable bits are writable. The read data is combinational on the address.

## Requirements
- R1: After rst_n the software reset bit (address 3 bit 0) reads 1 and eng_rst is high. From the cycle after that bit is 1, and for as long as it stays 1: register 7 reads 0x08, the conflict and overrun flags read 0, eng_load stays low, and writes to register 7 and to the transmit buffer are ignored.
- R2: With software reset clear, a write to address 6 clears the tx flag (register 7 bit 3) from the next cycle. While a byte is pending and eng_ready is high, eng_load is high and eng_tx_byte carries the byte. The tx flag reads 1 from the cycle after the load.
- R3: With software reset clear, an eng_rx_strobe pulse stores eng_rx_byte in the receive buffer (address 5) and sets the rx flag (register 7 bit 2) from the next cycle.
- R4: A strobe that arrives while the rx flag is set sets the overrun flag (status bit 5). A bus read of address 5 clears both the rx flag and the overrun flag. A write to status bit 5 has no effect.
- R5: When frame control bit 4 (7-bit length) is 1, the receive buffer bit 7 reads 0 and transmit buffer writes store bit 7 as 0.
- R6: When status bit 7 (listen) is 1, rx_serial follows tx_serial. Otherwise rx_serial follows miso_in.
- R7: Frame control (address 2) drives cfg_phase from bit 7, cfg_pol from bit 6, cfg_msb_first from bit 5, cfg_seven from bit 4, cfg_master from bit 3, cfg_mode from bits 2:1 and cfg_sync from bit 0.
- R8: irq_tx is high exactly when the tx flag and the tx enable are both 1. irq_rx is high exactly when the rx flag and the rx enable are both 1.
- R9: cfg_divisor equals the address-0 byte plus 256 times the address-1 byte.
- R10: Status bit 0 reads eng_busy. An eng_conflict pulse sets status bit 6, and a status write loads bit 6 from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on address 5) |
| bus_rdata | output | 8 | Read data for bus_addr |
| eng_ready | input | 1 | Engine shift register can accept a byte |
| eng_load | output | 1 | Pending byte is handed to the engine this cycle |
| eng_tx_byte | output | 8 | Transmit buffer contents |
| eng_rx_strobe | input | 1 | Engine delivers a received character |
| eng_rx_byte | input | 8 | Received character |
| eng_busy | input | 1 | Engine is transferring |
| eng_conflict | input | 1 | Engine saw a bus conflict |
| eng_rst | output | 1 | Holds the engine in reset |
| tx_serial | input | 1 | Engine serial output |
| miso_in | input | 1 | External serial data input |
| rx_serial | output | 1 | Serial data routed to the engine receiver |
| cfg_phase | output | 1 | Clock phase select |
| cfg_pol | output | 1 | Clock idle polarity |
| cfg_msb_first | output | 1 | Bit order |
| cfg_seven | output | 1 | 7-bit character length |
| cfg_master | output | 1 | Master select |
| cfg_mode | output | 2 | Pin mode |
| cfg_sync | output | 1 | Synchronous enable |
| cfg_divisor | output | 16 | Bit clock divisor |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The assertions assume that eng_rx_strobe and the bus strobes are single-cycle and synchronous to clk. They also assume that a bus read and a bus write never target address 5 in the same cycle. The stimulus drives every input at the falling edge and raises each strobe for exactly one cycle. It holds eng_ready low except when it deliberately lets a pending byte go, so that load timing is always under test control. A strobe that coincides with a read is never issued, so every overrun case in the run comes from a character that is truly unread.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_FRAME  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RSTCTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
    localparam logic [ADDR_W-1:0] A_RXBUF  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TXBUF  = 3'd6;
    localparam logic [ADDR_W-1:0] A_IRQ    = 3'd7;

    // field order follows bit 7 down to bit 0 of the frame control byte
    typedef struct packed {
        logic       phase;
        logic       pol;
        logic       msb_first;
        logic       seven;
        logic       master;
        logic [1:0] mode;
        logic       sync;
    } frame_t;

    typedef struct packed {
        frame_t            frame;
        logic              swrst;
        logic [BYTE_W-1:0] div_lo;
        logic [BYTE_W-1:0] div_hi;
        logic              listen;
        logic              conflict;
        logic [1:0]        ie;      // [1] tx, [0] rx
    } cfg_state_t;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] data;
    } tx_state_t;

    typedef struct packed {
        logic              flag;
        logic              ovr;
        logic [BYTE_W-1:0] data;
    } rx_state_t;
endpackage

// File: rtl/spi_rf_cfg.sv
module spi_rf_cfg
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_frame,
    input  logic              wr_rstctl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_status,
    input  logic              wr_irq,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              conflict_evt,
    output frame_t            frame,
    output logic              swrst,
    output logic [DIV_W-1:0]  divisor,
    output logic              listen,
    output logic              conflict,
    output logic [1:0]        ie
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_frame)  st_d.frame  = frame_t'(wdata);
        if (wr_rstctl) st_d.swrst  = wdata[0];
        if (wr_lo)     st_d.div_lo = wdata;
        if (wr_hi)     st_d.div_hi = wdata;
        if (wr_status) begin
            st_d.listen   = wdata[7];
            st_d.conflict = wdata[6];
        end
        if (conflict_evt) st_d.conflict = 1'b1;
        if (wr_irq)       st_d.ie = wdata[1:0];
        if (st_q.swrst) begin
            st_d.ie       = '0;
            st_d.conflict = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.swrst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame    = st_q.frame;
    assign swrst    = st_q.swrst;
    assign divisor  = {st_q.div_hi, st_q.div_lo};
    assign listen   = st_q.listen;
    assign conflict = st_q.conflict;
    assign ie       = st_q.ie;

    assert_reset_clears_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (ie == 2'b00 && !conflict));
    assert_conflict_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_evt && !swrst) |=> conflict);
endmodule

// File: rtl/spi_rf_txbuf.sv
module spi_rf_txbuf
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swrst,
    input  logic              seven,
    input  logic              wr_tx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              eng_ready,
    output logic              tx_flag,
    output logic              load,
    output logic [BYTE_W-1:0] data
);
    tx_state_t st_d, st_q;
    logic [BYTE_W-1:0] masked;

    assign masked = seven ? {1'b0, wdata[BYTE_W-2:0]} : wdata;
    assign load   = st_q.pend && eng_ready && !swrst;

    always_comb begin
        st_d = st_q;
        if (swrst) begin
            st_d.pend = 1'b0;
        end else if (wr_tx) begin
            st_d.pend = 1'b1;
            st_d.data = masked;
        end else if (load) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_flag = !st_q.pend;
    assign data    = st_q.data;

    assert_write_clears_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !swrst) |=> !tx_flag);
    assert_load_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_tx) |=> tx_flag);
    assert_tx_seven_clears_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !swrst && seven) |=> !data[BYTE_W-1]);
endmodule

// File: rtl/spi_rf_rxbuf.sv
module spi_rf_rxbuf
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swrst,
    input  logic              seven,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rd_rx,
    output logic              rx_flag,
    output logic              ovr,
    output logic [BYTE_W-1:0] data
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swrst) begin
            st_d.flag = 1'b0;
            st_d.ovr  = 1'b0;
        end else begin
            if (rd_rx) begin
                st_d.flag = 1'b0;
                st_d.ovr  = 1'b0;
            end
            if (strobe) begin
                if (st_q.flag && !rd_rx) st_d.ovr = 1'b1;
                st_d.flag = 1'b1;
                st_d.data = seven ? {1'b0, rx_byte[BYTE_W-2:0]} : rx_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_flag = st_q.flag;
    assign ovr     = st_q.ovr;
    assign data    = st_q.data;

    assert_strobe_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !swrst) |=> rx_flag);
    assert_read_clears_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !strobe) |=> (!rx_flag && !ovr));
    assert_unread_overruns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !swrst && rx_flag && !rd_rx) |=> ovr);
    assert_rx_seven_clears_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !swrst && seven) |=> !data[BYTE_W-1]);
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              eng_ready,
    output logic              eng_load,
    output logic [BYTE_W-1:0] eng_tx_byte,
    input  logic              eng_rx_strobe,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              eng_busy,
    input  logic              eng_conflict,
    output logic              eng_rst,
    input  logic              tx_serial,
    input  logic              miso_in,
    output logic              rx_serial,
    output logic              cfg_phase,
    output logic              cfg_pol,
    output logic              cfg_msb_first,
    output logic              cfg_seven,
    output logic              cfg_master,
    output logic [1:0]        cfg_mode,
    output logic              cfg_sync,
    output logic [DIV_W-1:0]  cfg_divisor,
    output logic              irq_tx,
    output logic              irq_rx
);
    frame_t            frame;
    logic              swrst, listen, conflict, tx_flag, rx_flag, rx_ovr;
    logic [1:0]        ie;
    logic [BYTE_W-1:0] rx_data;
    logic [BYTE_W-1:0] wr_sel;

    always_comb begin
        wr_sel = '0;
        if (bus_wr) wr_sel[bus_addr] = 1'b1;
    end

    spi_rf_cfg u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_frame(wr_sel[A_FRAME]), .wr_rstctl(wr_sel[A_RSTCTL]),
        .wr_lo(wr_sel[A_DIV_LO]), .wr_hi(wr_sel[A_DIV_HI]),
        .wr_status(wr_sel[A_STATUS]), .wr_irq(wr_sel[A_IRQ]),
        .wdata(bus_wdata), .conflict_evt(eng_conflict),
        .frame(frame), .swrst(swrst), .divisor(cfg_divisor),
        .listen(listen), .conflict(conflict), .ie(ie)
    );

    spi_rf_txbuf u_tx (
        .clk(clk), .rst_n(rst_n), .swrst(swrst), .seven(frame.seven),
        .wr_tx(wr_sel[A_TXBUF]), .wdata(bus_wdata), .eng_ready(eng_ready),
        .tx_flag(tx_flag), .load(eng_load), .data(eng_tx_byte)
    );

    spi_rf_rxbuf u_rx (
        .clk(clk), .rst_n(rst_n), .swrst(swrst), .seven(frame.seven),
        .strobe(eng_rx_strobe), .rx_byte(eng_rx_byte),
        .rd_rx(bus_rd && (bus_addr == A_RXBUF)),
        .rx_flag(rx_flag), .ovr(rx_ovr), .data(rx_data)
    );

    always_comb begin
        case (bus_addr)
            A_DIV_LO: bus_rdata = cfg_divisor[BYTE_W-1:0];
            A_DIV_HI: bus_rdata = cfg_divisor[DIV_W-1:BYTE_W];
            A_FRAME:  bus_rdata = frame;
            A_RSTCTL: bus_rdata = {{(BYTE_W-1){1'b0}}, swrst};
            A_STATUS: bus_rdata = {listen, conflict, rx_ovr, 4'b0000, eng_busy};
            A_RXBUF:  bus_rdata = rx_data;
            A_TXBUF:  bus_rdata = eng_tx_byte;
            default:  bus_rdata = {4'b0000, tx_flag, rx_flag, ie};
        endcase
    end

    assign rx_serial     = listen ? tx_serial : miso_in;
    assign eng_rst       = swrst;
    assign irq_tx        = tx_flag && ie[1];
    assign irq_rx        = rx_flag && ie[0];
    assign cfg_phase     = frame.phase;
    assign cfg_pol       = frame.pol;
    assign cfg_msb_first = frame.msb_first;
    assign cfg_seven     = frame.seven;
    assign cfg_master    = frame.master;
    assign cfg_mode      = frame.mode;
    assign cfg_sync      = frame.sync;

    assert_reset_flag_mix_R1: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (tx_flag && !rx_flag && !rx_ovr));
    assert_no_load_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |-> !eng_load);
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (!irq_tx && !irq_rx));
endmodule

// File: tb/spi_regfile_tb_top.sv
`timescale 1ns/1ps
module spi_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       eng_ready = 1'b0, eng_load;
    logic [7:0] eng_tx_byte;
    logic       eng_rx_strobe = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic       eng_busy = 1'b0, eng_conflict = 1'b0, eng_rst;
    logic       tx_serial = 1'b0, miso_in = 1'b0, rx_serial;
    logic       cfg_phase, cfg_pol, cfg_msb_first, cfg_seven, cfg_master, cfg_sync;
    logic [1:0] cfg_mode;
    logic [15:0] cfg_divisor;
    logic       irq_tx, irq_rx;

    always #2 clk = ~clk;

    spi_regfile dut_i (.*);

    int vectors = 0, miss = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    bit       m_swrst, m_listen, m_conf, m_ovr, m_rxf, m_pend;
    bit [1:0] m_ie;
    bit [7:0] m_lo, m_hi, m_frame, m_rxd, m_txd;

    task automatic chk(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            miss++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return m_frame;
            3: return m_swrst;
            4: return (m_listen << 7) | (m_conf << 6) | (m_ovr << 5) | eng_busy;
            5: return m_rxd;
            6: return m_txd;
            default: return ((!m_pend) << 3) | (m_rxf << 2) | m_ie;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        case (a)
            0, 1: return "R9 divisor read";
            2: return "R7 frame read";
            3: return "R1 reset bit read";
            4: return "R10 status read";
            5: return "R3 rx buffer read";
            6: return "R5 tx buffer read";
            default: return "R8 irq register read";
        endcase
    endfunction

    task automatic compare_all();
        chk(rd_tag(bus_addr), bus_rdata, exp_rdata(bus_addr));
        chk("R2 load", eng_load, m_pend && eng_ready && !m_swrst);
        chk("R2 tx byte", eng_tx_byte, m_txd);
        chk("R1 engine reset", eng_rst, m_swrst);
        chk("R6 loopback", rx_serial, m_listen ? tx_serial : miso_in);
        chk("R7 frame pins", {cfg_phase, cfg_pol, cfg_msb_first, cfg_seven, cfg_master, cfg_mode, cfg_sync}, m_frame);
        chk("R9 divisor", cfg_divisor, m_lo + 256 * m_hi);
        chk("R8 tx irq", irq_tx, !m_pend && m_ie[1]);
        chk("R8 rx irq", irq_rx, m_rxf && m_ie[0]);
    endtask

    task automatic update();
        bit ld, rd5, n_ovr, n_rxf;
        if (!rst_n) begin
            m_swrst = 1; m_listen = 0; m_conf = 0; m_ovr = 0; m_rxf = 0; m_pend = 0;
            m_ie = 0; m_lo = 0; m_hi = 0; m_frame = 0; m_rxd = 0; m_txd = 0;
            return;
        end
        ld  = m_pend && eng_ready && !m_swrst;
        rd5 = bus_rd && bus_addr == 5;
        n_ovr = m_ovr; n_rxf = m_rxf;
        if (m_swrst) begin
            n_ovr = 0; n_rxf = 0;
        end else begin
            if (rd5) begin n_ovr = 0; n_rxf = 0; end
            if (eng_rx_strobe) begin
                if (m_rxf && !rd5) n_ovr = 1;
                n_rxf = 1;
                m_rxd = m_frame[4] ? (eng_rx_byte & 8'h7f) : eng_rx_byte;
            end
        end
        if (m_swrst) m_pend = 0;
        else if (bus_wr && bus_addr == 6) begin
            m_pend = 1;
            m_txd = m_frame[4] ? (bus_wdata & 8'h7f) : bus_wdata;
        end else if (ld) m_pend = 0;
        if (bus_wr && bus_addr == 4) begin m_listen = bus_wdata[7]; m_conf = bus_wdata[6]; end
        if (eng_conflict) m_conf = 1;
        if (bus_wr && bus_addr == 7) m_ie = bus_wdata[1:0];
        if (m_swrst) begin m_ie = 0; m_conf = 0; end
        if (bus_wr && bus_addr == 0) m_lo = bus_wdata;
        if (bus_wr && bus_addr == 1) m_hi = bus_wdata;
        if (bus_wr && bus_addr == 2) m_frame = bus_wdata;
        m_ovr = n_ovr; m_rxf = n_rxf;
        if (bus_wr && bus_addr == 3) m_swrst = bus_wdata[0];
    endtask

    task automatic settle();  #1; compare_all(); endtask
    task automatic advance(); @(posedge clk); update(); @(negedge clk); endtask
    task automatic step();    settle(); advance(); endtask

    task automatic wr(int a, int d);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1; step(); bus_wr = 0;
    endtask
    task automatic rd(int a);
        bus_addr = 3'(a); bus_rd = 1; step(); bus_rd = 0;
    endtask
    task automatic peek(string tag, int a, int exp);
        bus_addr = 3'(a); settle(); chk(tag, bus_rdata, exp); advance();
    endtask
    task automatic rx_push(int d);
        eng_rx_byte = 8'(d); eng_rx_strobe = 1; step(); eng_rx_strobe = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            miss++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        update();
        @(negedge clk);
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        peek("R1 reset bit after power-up", 3, 8'h01);
        peek("R1 flags during reset", 7, 8'h08);
        wr(7, 8'h03);
        peek("R1 enable write ignored in reset", 7, 8'h08);
        eng_ready = 1;
        wr(6, 8'h55);
        settle(); chk("R1 no load in reset", eng_load, 0); advance();
        eng_ready = 0;
        // R9 divisor
        wr(0, 8'h34); wr(1, 8'h12);
        settle(); chk("R9 divisor combine", cfg_divisor, 16'h1234); advance();
        // R7 frame fields: 1010_0101
        wr(2, 8'hA5);
        settle();
        chk("R7 phase bit7", cfg_phase, 1); chk("R7 msb bit5", cfg_msb_first, 1);
        chk("R7 mode bits2:1", cfg_mode, 2); chk("R7 sync bit0", cfg_sync, 1);
        chk("R7 master bit3", cfg_master, 0);
        advance();
        // leave reset, enable interrupts
        wr(3, 0);
        wr(7, 8'h03);
        settle(); chk("R8 tx irq when empty", irq_tx, 1); chk("R8 rx irq idle", irq_rx, 0); advance();
        // R2 transmit handshake
        wr(6, 8'hC3);
        peek("R2 write clears tx flag", 7, 8'h03);
        peek("R2 buffer holds byte", 6, 8'hC3);
        step(); step();
        eng_ready = 1;
        settle(); chk("R2 load when ready", eng_load, 1); chk("R2 byte to engine", eng_tx_byte, 8'hC3); advance();
        eng_ready = 0;
        peek("R2 flag after load", 7, 8'h0B);
        // R3 / R4 receive and overrun
        rx_push(8'h5A);
        peek("R3 rx flag set", 7, 8'h0F);
        peek("R3 rx data", 5, 8'h5A);
        rx_push(8'h66);
        peek("R4 overrun set", 4, 8'h20);
        wr(4, 8'h00);
        peek("R4 overrun write ignored", 4, 8'h20);
        rd(5);
        peek("R4 read clears rx flag", 7, 8'h0B);
        peek("R4 read clears overrun", 4, 8'h00);
        // R5 seven-bit mode
        wr(2, 8'hB5);
        rx_push(8'hFF);
        peek("R5 rx msb cleared", 5, 8'h7F);
        wr(6, 8'h81);
        peek("R5 tx msb cleared", 6, 8'h01);
        eng_ready = 1; step(); eng_ready = 0;
        // R6 loopback
        wr(4, 8'h80);
        tx_serial = 1; miso_in = 0;
        settle(); chk("R6 listen follows tx", rx_serial, 1); advance();
        tx_serial = 0; miso_in = 1;
        settle(); chk("R6 listen ignores miso", rx_serial, 0); advance();
        wr(4, 8'h00);
        settle(); chk("R6 normal path", rx_serial, 1); advance();
        // R10 status
        eng_busy = 1;
        peek("R10 busy bit", 4, 8'h01);
        eng_conflict = 1; step(); eng_conflict = 0;
        peek("R10 conflict set", 4, 8'h41);
        wr(4, 8'h00);
        peek("R10 conflict cleared by write", 4, 8'h01);
        eng_busy = 0;
        // R1 software reset again
        eng_conflict = 1; step(); eng_conflict = 0;
        wr(6, 8'h22);
        wr(3, 1);
        step();
        peek("R1 reset flag mix", 7, 8'h08);
        peek("R1 reset clears status flags", 4, 8'h00);
        settle(); chk("R1 irq quiet", irq_rx, 0); advance();
        step();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule